// File: doc/BRIEF.md
# Time Base and Timer Unit

This block keeps a 64-bit time base and drives three timers from it: a 32-bit decrementer that can optionally reload itself, a fixed-interval timer that fires whenever a selected time-base bit rises, and a two-stage watchdog. The time base advances on every clock or on each rising edge of an external tick input, chosen by a select pin. All three timers move only when the time base moves.

Software reaches the block through a simple single-cycle register port. Through it, software can load or read the time base, the decrementer and its reload value, and can set the control word. Sticky status bits drive the interrupt outputs and are cleared by writing ones. The watchdog raises a critical interrupt when it first expires. If software has not cleared that stage by the next expiry, the watchdog raises a reset request together with a reset type chosen by software. Interrupt routing and the reset generator themselves lie outside this block.

Top module: `tbu_top`

## Requirements
- R1: The time base advances by exactly one per tick, with carry across all 64 bits. With `tick_sel_i`=0 a tick occurs every clock. With `tick_sel_i`=1 a tick occurs once for each rising edge of `ext_tick_i`, after the input has passed through a synchronizer.
- R2: The time base holds its value in any cycle without a tick. A write to address 0 loads the low 32 bits and a write to address 1 loads the high 32 bits. A write takes priority over a tick in the same cycle.
- R3: The decrementer (address 2) drops by one on each tick while it is non-zero. A write loads it directly.
- R4: A tick that takes the decrementer from 1 to 0 sets status bit 0, which drives `dec_irq_o`. Without reload the decrementer then stays at 0.
- R5: When reload is enabled (control bit 0) and the decrementer would reach 0, it instead loads the value held in the reload register (address 3), and status bit 0 is still set.
- R6: The fixed-interval timer watches time-base bit FIT_BASE+FIT_STEP*s, where s is control bits [2:1]. A tick that moves that bit from 0 to 1 sets status bit 1, which drives `fit_irq_o`.
- R7: With the watchdog enabled (control bit 7), a tick that moves bit WDG_BASE+WDG_STEP*w from 0 to 1 is an expiry, where w is control bits [4:3]. A first expiry, while status bit 2 is clear, sets status bit 2, which drives `wdg_irq_o`.
- R8: An expiry while status bit 2 is set, with reset type (control bits [6:5]) non-zero, sets status bit 3. This drives `wdg_rst_req_o`, and `wdg_rst_type_o` shows the type latched at that expiry.
- R9: With reset type 00, a second expiry produces no reset request.
- R10: Status bits are sticky. Writing a 1 to a status bit (address 5) clears it, and writing a 0 leaves it unchanged. After status bit 2 is cleared, the next expiry counts as a first expiry again.
- R11: Registers read back combinationally on `reg_rdata_o`: time base low/high (0/1), decrementer (2), reload (3), control bits [7:0] (4), and status bits [3:0] (5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_sel_i | input | 1 | 0: tick every clock, 1: tick on external edge |
| ext_tick_i | input | 1 | External tick source (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| dec_irq_o | output | 1 | Decrementer interrupt |
| fit_irq_o | output | 1 | Fixed-interval interrupt |
| wdg_irq_o | output | 1 | Watchdog critical interrupt |
| wdg_rst_req_o | output | 1 | Watchdog reset request |
| wdg_rst_type_o | output | 2 | Requested reset type, 0 when no request |

## Verification
A wrong time-base count shows up as a wrong read-back after a single tick. It also shifts every fixed-interval and watchdog event by whole ticks, so stepping the external tick one pulse at a time places each interrupt at the exact pulse where it should first appear. A corrupted decrementer or reload value shows on the next reading, or at its zero crossing within a few ticks. A watchdog stage bit stuck in the wrong state shows as a reset request one expiry too early, or an interrupt one expiry too late, and a 16-tick period is enough to expose it.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned TBW = 64;
  localparam int unsigned AW  = 3;
  localparam int unsigned SW  = 4;

  typedef enum logic [AW-1:0] {
    A_TBL = 3'd0,
    A_TBH = 3'd1,
    A_DEC = 3'd2,
    A_REL = 3'd3,
    A_CTL = 3'd4,
    A_STS = 3'd5
  } addr_e;

  typedef struct packed {
    logic       wdg_en;
    logic [1:0] rst_type;
    logic [1:0] wdg_sel;
    logic [1:0] fit_sel;
    logic       reload_en;
  } ctrl_t;

  localparam int unsigned S_DEC  = 0;
  localparam int unsigned S_FIT  = 1;
  localparam int unsigned S_WST  = 2;
  localparam int unsigned S_WRST = 3;
endpackage

// File: rtl/tbu_timebase.sv
module tbu_timebase #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TBW         = 64,
  parameter int unsigned DW          = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_sel_i,
  input  logic           ext_tick_i,
  input  logic           wr_lo_i,
  input  logic           wr_hi_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           tick_o,
  output logic [TBW-1:0] tb_o,
  output logic [TBW-1:0] tb_inc_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   edge_q;
  logic [TBW-1:0]         tb_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= ext_tick_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) edge_q <= 1'b0;
    else         edge_q <= sync_q[LAST];

  assign tick_o   = tick_sel_i ? (sync_q[LAST] & ~edge_q) : 1'b1;
  assign tb_inc_o = tb_q + {{(TBW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) tb_q[DW-1:0]     <= wdata_i;
      if (wr_hi_i) tb_q[TBW-1:DW]   <= wdata_i;
    end else if (tick_o) begin
      tb_q <= tb_inc_o;
    end
  end

  assign tb_o = tb_q;

  AST_TB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !wr_lo_i && !wr_hi_i) |=> tb_q == $past(tb_q) + 64'd1); // R1
  AST_TB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !wr_lo_i && !wr_hi_i) |=> $stable(tb_q)); // R2
endmodule

// File: rtl/tbu_bit_rise.sv
module tbu_bit_rise #(
  parameter int unsigned TBW  = 64,
  parameter int unsigned BASE = 8,
  parameter int unsigned STEP = 4
) (
  input  logic           tick_i,
  input  logic [1:0]     sel_i,
  input  logic [TBW-1:0] tb_i,
  input  logic [TBW-1:0] tb_inc_i,
  output logic           rise_o
);
  logic [TBW-1:0] mask;
  int unsigned    pos;

  always_comb begin
    pos  = BASE + STEP * int'(sel_i);
    mask = {{(TBW-1){1'b0}}, 1'b1} << pos;
  end

  // bit is 0 now and 1 after this tick
  assign rise_o = tick_i & ~(|(tb_i & mask)) & (|(tb_inc_i & mask));
endmodule

// File: rtl/tbu_dec.sv
module tbu_dec #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_dec_i,
  input  logic          wr_rel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          reload_en_i,
  input  logic          clr_i,
  output logic [DW-1:0] dec_o,
  output logic [DW-1:0] rel_o,
  output logic          st_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] dec_q, rel_q;
  logic          st_q, hit;

  assign hit = tick_i && !wr_dec_i && (dec_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       rel_q <= '0;
    else if (wr_rel_i) rel_q <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     dec_q <= '0;
    else if (wr_dec_i)               dec_q <= wdata_i;
    else if (hit)                    dec_q <= reload_en_i ? rel_q : '0;
    else if (tick_i && dec_q != '0)  dec_q <= dec_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= 1'b0;
    else if (hit)   st_q <= 1'b1;
    else if (clr_i) st_q <= 1'b0;
  end

  assign dec_o = dec_q;
  assign rel_o = rel_q;
  assign st_o  = st_q;

  AST_DEC_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_q == '0 && !wr_dec_i) |=> dec_q == '0); // R4
  AST_DEC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_dec_i && dec_q == ONE) |=> st_q); // R4
  AST_DEC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_dec_i && dec_q == ONE && reload_en_i) |=> dec_q == $past(rel_q)); // R5
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_dec_i && dec_q > ONE) |=> dec_q == $past(dec_q) - ONE); // R3
endmodule

// File: rtl/tbu_wdog.sv
module tbu_wdog (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       en_i,
  input  logic [1:0] type_i,
  input  logic       clr_stage_i,
  input  logic       clr_rst_i,
  output logic       stage_o,
  output logic       rst_o,
  output logic [1:0] type_o
);
  logic       stage_q, rst_q, fire;
  logic [1:0] type_q;

  assign fire = expire_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  stage_q <= 1'b0;
    else if (fire && !stage_q)    stage_q <= 1'b1;
    else if (clr_stage_i)         stage_q <= 1'b0;
  end

  // second stage: only with a non-zero reset type
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      type_q <= 2'b00;
    end else if (fire && stage_q && type_i != 2'b00 && !rst_q) begin
      rst_q  <= 1'b1;
      type_q <= type_i;
    end else if (clr_rst_i) begin
      rst_q  <= 1'b0;
    end
  end

  assign stage_o = stage_q;
  assign rst_o   = rst_q;
  assign type_o  = rst_q ? type_q : 2'b00;

  AST_WDG_TWO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(stage_q)); // R8
  AST_WDG_TYPE_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> type_o != 2'b00); // R9
  AST_WDG_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !stage_q) |=> stage_q && $stable(rst_q)); // R7
endmodule

// File: rtl/tbu_top.sv
module tbu_top #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FIT_BASE    = 8,
  parameter int unsigned FIT_STEP    = 4,
  parameter int unsigned WDG_BASE    = 12,
  parameter int unsigned WDG_STEP    = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_sel_i,
  input  logic        ext_tick_i,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        dec_irq_o,
  output logic        fit_irq_o,
  output logic        wdg_irq_o,
  output logic        wdg_rst_req_o,
  output logic [1:0]  wdg_rst_type_o
);
  import tbu_pkg::*;

  localparam int unsigned CW = $bits(ctrl_t);

  ctrl_t          ctrl_q;
  logic           tick, fit_rise, wdg_rise, fit_st_q;
  logic           wr_tbl, wr_tbh, wr_dec, wr_rel, wr_ctl, wr_sts;
  logic [SW-1:0]  clr;
  logic [TBW-1:0] tb, tb_inc;
  logic [DW-1:0]  dec_val, rel_val;
  logic           dec_st, wst, wrst;
  logic [SW-1:0]  status;

  always_comb begin
    wr_tbl = 1'b0; wr_tbh = 1'b0; wr_dec = 1'b0;
    wr_rel = 1'b0; wr_ctl = 1'b0; wr_sts = 1'b0;
    if (reg_wr_i) begin
      case (addr_e'(reg_addr_i))
        A_TBL:   wr_tbl = 1'b1;
        A_TBH:   wr_tbh = 1'b1;
        A_DEC:   wr_dec = 1'b1;
        A_REL:   wr_rel = 1'b1;
        A_CTL:   wr_ctl = 1'b1;
        A_STS:   wr_sts = 1'b1;
        default: ;
      endcase
    end
  end

  assign clr = wr_sts ? reg_wdata_i[SW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     ctrl_q <= '0;
    else if (wr_ctl) ctrl_q <= ctrl_t'(reg_wdata_i[CW-1:0]);

  tbu_timebase #(.SYNC_STAGES(SYNC_STAGES), .TBW(TBW), .DW(DW)) u_tb (
    .clk_i, .rst_ni, .tick_sel_i, .ext_tick_i,
    .wr_lo_i(wr_tbl), .wr_hi_i(wr_tbh), .wdata_i(reg_wdata_i),
    .tick_o(tick), .tb_o(tb), .tb_inc_o(tb_inc)
  );

  tbu_dec #(.DW(DW)) u_dec (
    .clk_i, .rst_ni, .tick_i(tick),
    .wr_dec_i(wr_dec), .wr_rel_i(wr_rel), .wdata_i(reg_wdata_i),
    .reload_en_i(ctrl_q.reload_en), .clr_i(clr[S_DEC]),
    .dec_o(dec_val), .rel_o(rel_val), .st_o(dec_st)
  );

  tbu_bit_rise #(.TBW(TBW), .BASE(FIT_BASE), .STEP(FIT_STEP)) u_fit_rise (
    .tick_i(tick), .sel_i(ctrl_q.fit_sel), .tb_i(tb), .tb_inc_i(tb_inc), .rise_o(fit_rise)
  );

  tbu_bit_rise #(.TBW(TBW), .BASE(WDG_BASE), .STEP(WDG_STEP)) u_wdg_rise (
    .tick_i(tick), .sel_i(ctrl_q.wdg_sel), .tb_i(tb), .tb_inc_i(tb_inc), .rise_o(wdg_rise)
  );

  // a tick is suppressed by a time-base write, so is its event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            fit_st_q <= 1'b0;
    else if (fit_rise && !wr_tbl && !wr_tbh) fit_st_q <= 1'b1;
    else if (clr[S_FIT])                    fit_st_q <= 1'b0;
  end

  tbu_wdog u_wdog (
    .clk_i, .rst_ni,
    .expire_i(wdg_rise && !wr_tbl && !wr_tbh),
    .en_i(ctrl_q.wdg_en), .type_i(ctrl_q.rst_type),
    .clr_stage_i(clr[S_WST]), .clr_rst_i(clr[S_WRST]),
    .stage_o(wst), .rst_o(wrst), .type_o(wdg_rst_type_o)
  );

  always_comb begin
    status         = '0;
    status[S_DEC]  = dec_st;
    status[S_FIT]  = fit_st_q;
    status[S_WST]  = wst;
    status[S_WRST] = wrst;
  end

  always_comb begin
    case (addr_e'(reg_addr_i))
      A_TBL:   reg_rdata_o = tb[DW-1:0];
      A_TBH:   reg_rdata_o = tb[TBW-1:DW];
      A_DEC:   reg_rdata_o = dec_val;
      A_REL:   reg_rdata_o = rel_val;
      A_CTL:   reg_rdata_o = {{(DW-CW){1'b0}}, ctrl_q};
      A_STS:   reg_rdata_o = {{(DW-SW){1'b0}}, status};
      default: reg_rdata_o = '0;
    endcase
  end

  assign dec_irq_o     = dec_st;
  assign fit_irq_o     = fit_st_q;
  assign wdg_irq_o     = wst;
  assign wdg_rst_req_o = wrst;

  AST_FIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fit_rise && !reg_wr_i) |=> fit_irq_o); // R6
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fit_irq_o && !clr[S_FIT]) |=> fit_irq_o); // R10
endmodule

// File: tb/tbu_top_tb_top.sv
module tbu_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_sel_i = 1'b0;
  logic        ext_tick_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dec_irq_o, fit_irq_o, wdg_irq_o, wdg_rst_req_o;
  logic [1:0]  wdg_rst_type_o;

  always #2 clk_i = ~clk_i;

  tbu_top #(.SYNC_STAGES(2), .FIT_BASE(2), .FIT_STEP(1), .WDG_BASE(3), .WDG_STEP(1)) dut_i (
    .clk_i, .rst_ni, .tick_sel_i, .ext_tick_i, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .dec_irq_o, .fit_irq_o, .wdg_irq_o, .wdg_rst_req_o, .wdg_rst_type_o
  );

  typedef struct {string req; logic [31:0] val;} item_t;
  item_t       exp_q[$];
  logic [31:0] act_q[$];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  // scoreboard monitor
  initial begin
    item_t       e;
    logic [31:0] a;
    forever begin
      @(posedge clk_i);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_chk++;
        if (a !== e.val) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", e.req, a, e.val);
        end
      end
    end
  end

  task automatic push(string req, logic [31:0] act, logic [31:0] exp);
    exp_q.push_back('{req, exp});
    act_q.push_back(act);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic chk_rd(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    push(req, v, exp);
  endtask

  task automatic chk_sts(string req, int bitn, logic exp);
    logic [31:0] v;
    rd(3'd5, v);
    push(req, {31'b0, v[bitn]}, {31'b0, exp});
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) ext_tick_i = 1'b1;
      repeat (2) @(negedge clk_i);
      ext_tick_i = 1'b0;
      repeat (5) @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] t0, t1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 reset state
    chk_rd("R11 dec reset", 3'd2, 32'h0);
    chk_rd("R11 ctrl reset", 3'd4, 32'h0);
    chk_rd("R11 status reset", 3'd5, 32'h0);

    // R1 free-running tick
    @(negedge clk_i); reg_addr_i = 3'd0; #1 t0 = reg_rdata_o;
    repeat (10) @(negedge clk_i);
    #1 t1 = reg_rdata_o;
    push("R1 free run +10", t1 - t0, 32'd10);

    // switch to external tick: frozen
    @(negedge clk_i) tick_sel_i = 1'b1;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h5);
    chk_rd("R2 write high", 3'd1, 32'h5);
    repeat (8) @(negedge clk_i);
    chk_rd("R2 hold low", 3'd0, 32'h0);
    chk_rd("R2 hold high", 3'd1, 32'h5);

    // R1 carry
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0);
    pulses(1);
    chk_rd("R1 carry low", 3'd0, 32'h0);
    chk_rd("R1 carry high", 3'd1, 32'h1);

    // R3 R4 decrement, stop at zero
    wr(3'd4, 32'h0);
    wr(3'd2, 32'd3);
    pulses(2);
    chk_rd("R3 dec step", 3'd2, 32'd1);
    chk_sts("R4 not yet", 0, 1'b0);
    pulses(1);
    chk_rd("R4 at zero", 3'd2, 32'd0);
    chk_sts("R4 status set", 0, 1'b1);
    push("R4 dec_irq_o", {31'b0, dec_irq_o}, 32'd1);
    pulses(1);
    chk_rd("R4 stays zero", 3'd2, 32'd0);

    // R10 write one to clear
    wr(3'd5, 32'h0);
    chk_sts("R10 zero write no effect", 0, 1'b1);
    wr(3'd5, 32'h1);
    chk_sts("R10 cleared", 0, 1'b0);
    push("R10 dec_irq_o low", {31'b0, dec_irq_o}, 32'd0);

    // R5 reload
    wr(3'd3, 32'd4);
    wr(3'd4, 32'h1);
    wr(3'd2, 32'd2);
    chk_rd("R11 reload readback", 3'd3, 32'd4);
    pulses(2);
    chk_rd("R5 reloaded", 3'd2, 32'd4);
    chk_sts("R5 status set", 0, 1'b1);
    pulses(1);
    chk_rd("R3 continues after reload", 3'd2, 32'd3);

    // R6 fixed interval on bit 3
    wr(3'd4, 32'h3);
    wr(3'd5, 32'hF);
    wr(3'd0, 32'h0);
    pulses(7);
    chk_sts("R6 before edge", 1, 1'b0);
    pulses(1);
    chk_sts("R6 on edge", 1, 1'b1);
    push("R6 fit_irq_o", {31'b0, fit_irq_o}, 32'd1);

    // R7 R8 watchdog on bit 3, type 2
    wr(3'd4, 32'hC0);
    chk_rd("R11 ctrl readback", 3'd4, 32'hC0);
    wr(3'd5, 32'hF);
    wr(3'd0, 32'h0);
    pulses(7);
    chk_sts("R7 before expiry", 2, 1'b0);
    pulses(1);
    chk_sts("R7 first expiry", 2, 1'b1);
    push("R7 wdg_irq_o", {31'b0, wdg_irq_o}, 32'd1);
    push("R7 no reset yet", {31'b0, wdg_rst_req_o}, 32'd0);
    pulses(15);
    chk_sts("R8 before second", 3, 1'b0);
    pulses(1);
    chk_sts("R8 second expiry", 3, 1'b1);
    push("R8 wdg_rst_req_o", {31'b0, wdg_rst_req_o}, 32'd1);
    push("R8 wdg_rst_type_o", {30'b0, wdg_rst_type_o}, 32'd2);

    // R10 restart of the sequence
    wr(3'd5, 32'hC);
    chk_sts("R10 stage cleared", 2, 1'b0);
    push("R10 reset cleared", {31'b0, wdg_rst_req_o}, 32'd0);
    pulses(16);
    chk_sts("R10 restart first stage", 2, 1'b1);
    chk_sts("R10 restart no reset", 3, 1'b0);

    // R9 type 00
    wr(3'd4, 32'h80);
    pulses(16);
    chk_sts("R9 no reset status", 3, 1'b0);
    push("R9 no reset pin", {31'b0, wdg_rst_req_o}, 32'd0);
    push("R9 type zero", {30'b0, wdg_rst_type_o}, 32'd0);

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule